// File: doc/BRIEF.md
# Branch and Skip Decision Unit

This unit sits after instruction decode in a small 8-bit processor pipeline. It receives an operation that has already been decoded, along with the current program counter, the status byte, a signed word offset, the comparison operands and a single test bit. From these it decides whether control flow leaves the straight-line path, and it computes the address of the next instruction. It also reports how many clock cycles the instruction occupies.

The unit covers four kinds of operation. Conditional branches test a chosen status bit or the signed relation formed from the negative and overflow flags. Relative jumps and calls always go to their target. Returns take a target address that the stack logic supplies. Skips test register equality or a single bit, and how far a taken skip moves depends on whether the following instruction is one word or two words long. Results are registered, so each accepted operation produces one result on the next clock.

Top module: `flow_decider`

## Requirements
- R1: While `rst` is high, the unit drives `res_valid`, `redirect`, `skipped`, `next_pc` and `cycles` to zero on every clock edge.
- R2: An operation accepted with `op_valid` high produces its result with `res_valid` high exactly one clock later. An idle cycle produces `res_valid` low on the next clock.
- R3: Operation code 0 and every code above 11 are sequential: `next_pc` = `pc` + 1, `cycles` = 1, and `redirect` and `skipped` both stay low.
- R4: Code 1 branches when status bit `sel` is 1, and code 2 branches when that bit is 0. The status bit positions are carry 0, zero 1, negative 2, overflow 3, sign 4, half-carry 5, transfer 6 and interrupt enable 7.
- R5: Code 3 (signed greater-or-equal) branches when status bit 2 XOR bit 3 is 0, and code 4 (signed less-than) branches when it is 1. Status bit 4 does not affect either decision.
- R6: A taken branch, jump or call sets `next_pc` = `pc` + `offset` + 1. Here `offset` is a 12-bit two's complement value, and the sum wraps modulo 2^10.
- R7: A conditional branch (codes 1 to 4) reports `cycles` = 2 and `redirect` = 1 when taken. When not taken, it reports `cycles` = 1, `redirect` = 0 and `next_pc` = `pc` + 1.
- R8: Code 5 (relative jump) is always taken and reports `cycles` = 2.
- R9: Code 6 (relative call) is always taken and reports `cycles` = 3.
- R10: Codes 7 (return) and 8 (interrupt return) set `next_pc` = `ret_pc`, `redirect` = 1 and `cycles` = 4.
- R11: The skip conditions are: code 9 skips when `reg_a` equals `reg_b`, code 10 skips when `test_bit` is 0, and code 11 skips when `test_bit` is 1. A taken skip sets `skipped` = 1 and `next_pc` = `pc` + 2 when `next_two_word` is 0, or `pc` + 3 when it is 1, wrapping modulo 2^10.
- R12: A skip reports `cycles` = 1 when not taken (with `next_pc` = `pc` + 1), 2 when it passes over a one-word instruction, and 3 when it passes over a two-word instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | A decoded operation is present this cycle |
| op | input | 4 | Operation code |
| pc | input | 10 | Address of the current instruction |
| sreg | input | 8 | Status flags |
| sel | input | 3 | Index of the status bit for codes 1 and 2 |
| offset | input | 12 | Signed relative word offset |
| test_bit | input | 1 | Bit under test for codes 10 and 11 |
| reg_a | input | 8 | First operand of the equality skip |
| reg_b | input | 8 | Second operand of the equality skip |
| next_two_word | input | 1 | The following instruction is two words long |
| ret_pc | input | 10 | Return address from the stack logic |
| res_valid | output | 1 | Result is valid |
| redirect | output | 1 | Control flow leaves the sequential path |
| skipped | output | 1 | The following instruction is skipped |
| next_pc | output | 10 | Address of the next instruction |
| cycles | output | 3 | Clock cycles the instruction takes |

## Verification
The hardest cases to reach from the ports are the ones where the target address wraps past either end of the 10-bit space. In each of them the offset sign, the program counter value and the skip length all have to line up. The stimulus table places the program counter next to 0x3FF or 0x000 with offsets chosen so that the sum crosses the boundary, once for a forward jump, once for a backward jump, once for the largest positive branch offset and once for a two-word skip. The table also includes a status byte with only the sign bit set, so that a design that uses the stored sign bit in place of N XOR V is caught.

// File: rtl/fd_pkg.sv
package fd_pkg;

  typedef enum logic [3:0] {
    FD_SEQ      = 4'd0,
    FD_BR_SET   = 4'd1,
    FD_BR_CLR   = 4'd2,
    FD_BR_GE    = 4'd3,
    FD_BR_LT    = 4'd4,
    FD_JMP      = 4'd5,
    FD_CALL     = 4'd6,
    FD_RET      = 4'd7,
    FD_RETI     = 4'd8,
    FD_SK_EQ    = 4'd9,
    FD_SK_CLR   = 4'd10,
    FD_SK_SET   = 4'd11
  } fd_op_e;

  localparam int FD_OP_W  = 4;
  localparam int FD_CYC_W = 3;

  // status flag positions
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;

  localparam logic [FD_CYC_W-1:0] CYC_ONE   = 3'd1;
  localparam logic [FD_CYC_W-1:0] CYC_TWO   = 3'd2;
  localparam logic [FD_CYC_W-1:0] CYC_THREE = 3'd3;
  localparam logic [FD_CYC_W-1:0] CYC_FOUR  = 3'd4;

endpackage

// File: rtl/fd_cond.sv
module fd_cond
  import fd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SR_W   = 8,
  localparam int SEL_W = $clog2(SR_W)
) (
  input  logic [FD_OP_W-1:0] op,
  input  logic [SR_W-1:0]    sreg,
  input  logic [SEL_W-1:0]   sel,
  input  logic               test_bit,
  input  logic [DATA_W-1:0]  reg_a,
  input  logic [DATA_W-1:0]  reg_b,
  output logic               br_take,
  output logic               skip_hit,
  output logic               is_ret,
  output logic               is_cond_br,
  output logic               is_skip
);

  fd_op_e kind;
  logic   signed_lt;

  assign kind      = fd_op_e'(op);
  assign signed_lt = sreg[FLAG_N] ^ sreg[FLAG_V];

  always_comb begin
    br_take    = 1'b0;
    skip_hit   = 1'b0;
    is_ret     = 1'b0;
    is_cond_br = 1'b0;
    is_skip    = 1'b0;
    case (kind)
      FD_BR_SET: begin is_cond_br = 1'b1; br_take = sreg[sel];  end
      FD_BR_CLR: begin is_cond_br = 1'b1; br_take = !sreg[sel]; end
      FD_BR_GE:  begin is_cond_br = 1'b1; br_take = !signed_lt; end
      FD_BR_LT:  begin is_cond_br = 1'b1; br_take = signed_lt;  end
      FD_JMP, FD_CALL: br_take = 1'b1;
      FD_RET, FD_RETI: is_ret = 1'b1;
      FD_SK_EQ:  begin is_skip = 1'b1; skip_hit = (reg_a == reg_b); end
      FD_SK_CLR: begin is_skip = 1'b1; skip_hit = !test_bit; end
      FD_SK_SET: begin is_skip = 1'b1; skip_hit = test_bit;  end
      default: ;
    endcase
  end

endmodule

// File: rtl/fd_target.sv
module fd_target #(
  parameter int PC_W  = 10,
  parameter int OFF_W = 12,
  localparam int SUM_W = ((PC_W > OFF_W) ? PC_W : OFF_W) + 1
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  input  logic             next_two_word,
  output logic [PC_W-1:0]  rel_pc,
  output logic [PC_W-1:0]  skip_pc,
  output logic [PC_W-1:0]  seq_pc
);

  // pc + signed k + 1, modulo 2^PC_W
  function automatic logic [PC_W-1:0] rel_dest(input logic [PC_W-1:0] base,
                                               input logic [OFF_W-1:0] k);
    logic [SUM_W-1:0] wide_b;
    logic [SUM_W-1:0] wide_k;
    logic [SUM_W-1:0] sum;
    wide_b = {{(SUM_W-PC_W){1'b0}}, base};
    wide_k = {{(SUM_W-OFF_W){k[OFF_W-1]}}, k};
    sum    = wide_b + wide_k + SUM_W'(1);
    return sum[PC_W-1:0];
  endfunction

  // skip the following one- or two-word instruction
  function automatic logic [PC_W-1:0] skip_dest(input logic [PC_W-1:0] base,
                                                input logic two_word);
    return base + (two_word ? PC_W'(3) : PC_W'(2));
  endfunction

  assign rel_pc  = rel_dest(pc, offset);
  assign skip_pc = skip_dest(pc, next_two_word);
  assign seq_pc  = pc + PC_W'(1);

endmodule

// File: rtl/fd_cycles.sv
module fd_cycles
  import fd_pkg::*;
(
  input  logic [FD_OP_W-1:0]  op,
  input  logic                br_take,
  input  logic                skip_hit,
  input  logic                next_two_word,
  output logic [FD_CYC_W-1:0] cycles
);

  fd_op_e kind;
  assign kind = fd_op_e'(op);

  always_comb begin
    case (kind)
      FD_BR_SET, FD_BR_CLR, FD_BR_GE, FD_BR_LT:
        cycles = br_take ? CYC_TWO : CYC_ONE;
      FD_JMP:          cycles = CYC_TWO;
      FD_CALL:         cycles = CYC_THREE;
      FD_RET, FD_RETI: cycles = CYC_FOUR;
      FD_SK_EQ, FD_SK_CLR, FD_SK_SET:
        cycles = !skip_hit ? CYC_ONE : (next_two_word ? CYC_THREE : CYC_TWO);
      default:         cycles = CYC_ONE;
    endcase
  end

endmodule

// File: rtl/flow_decider.sv
module flow_decider
  import fd_pkg::*;
#(
  parameter int PC_W   = 10,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 8,
  parameter int SR_W   = 8,
  localparam int SEL_W = $clog2(SR_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_valid,
  input  logic [FD_OP_W-1:0]  op,
  input  logic [PC_W-1:0]     pc,
  input  logic [SR_W-1:0]     sreg,
  input  logic [SEL_W-1:0]    sel,
  input  logic [OFF_W-1:0]    offset,
  input  logic                test_bit,
  input  logic [DATA_W-1:0]   reg_a,
  input  logic [DATA_W-1:0]   reg_b,
  input  logic                next_two_word,
  input  logic [PC_W-1:0]     ret_pc,
  output logic                res_valid,
  output logic                redirect,
  output logic                skipped,
  output logic [PC_W-1:0]     next_pc,
  output logic [FD_CYC_W-1:0] cycles
);

  // named decision events, also observed by the checker
  logic                br_take;
  logic                skip_hit;
  logic                is_ret;
  logic                is_cond_br;
  logic                is_skip;
  logic [PC_W-1:0]     rel_pc;
  logic [PC_W-1:0]     skip_pc;
  logic [PC_W-1:0]     seq_pc;
  logic [FD_CYC_W-1:0] cycles_w;
  logic [PC_W-1:0]     next_pc_w;
  logic                redirect_w;

  fd_cond #(.DATA_W(DATA_W), .SR_W(SR_W)) u_cond (
    .op(op), .sreg(sreg), .sel(sel), .test_bit(test_bit),
    .reg_a(reg_a), .reg_b(reg_b),
    .br_take(br_take), .skip_hit(skip_hit), .is_ret(is_ret),
    .is_cond_br(is_cond_br), .is_skip(is_skip)
  );

  fd_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
    .pc(pc), .offset(offset), .next_two_word(next_two_word),
    .rel_pc(rel_pc), .skip_pc(skip_pc), .seq_pc(seq_pc)
  );

  fd_cycles u_cycles (
    .op(op), .br_take(br_take), .skip_hit(skip_hit),
    .next_two_word(next_two_word), .cycles(cycles_w)
  );

  assign redirect_w = br_take | is_ret;

  always_comb begin
    if (is_ret)        next_pc_w = ret_pc;
    else if (br_take)  next_pc_w = rel_pc;
    else if (skip_hit) next_pc_w = skip_pc;
    else               next_pc_w = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      redirect  <= 1'b0;
      skipped   <= 1'b0;
      next_pc   <= '0;
      cycles    <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        redirect <= redirect_w;
        skipped  <= skip_hit;
        next_pc  <= next_pc_w;
        cycles   <= cycles_w;
      end
    end
  end

endmodule

// File: rtl/flow_decider_chk.sv
module flow_decider_chk #(
  parameter int PC_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input logic [PC_W-1:0] pc,
  input logic [PC_W-1:0] ret_pc,
  input logic            next_two_word,
  input logic            br_take,
  input logic            skip_hit,
  input logic            is_ret,
  input logic            is_cond_br,
  input logic            res_valid,
  input logic            redirect,
  input logic            skipped,
  input logic [PC_W-1:0] next_pc,
  input logic [2:0]      cycles
);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);

  p_idle_follows_r2: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_valid);

  p_seq_path_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !br_take && !skip_hit && !is_ret) |=>
      (!redirect && !skipped && next_pc == PC_W'($past(pc) + PC_W'(1))));

  p_cond_cycles_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_cond_br) |=>
      (cycles == ($past(br_take) ? 3'd2 : 3'd1) && redirect == $past(br_take)));

  p_return_r10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_ret) |=>
      (redirect && cycles == 3'd4 && next_pc == $past(ret_pc)));

  p_skip_dest_r11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && skip_hit) |=>
      (skipped && next_pc == PC_W'($past(pc) + ($past(next_two_word) ? PC_W'(3) : PC_W'(2)))));

  p_skip_cycles_r12: assert property (@(posedge clk) disable iff (rst)
    (op_valid && skip_hit) |=> (cycles == ($past(next_two_word) ? 3'd3 : 3'd2)));

  p_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({redirect, skipped}));

endmodule

bind flow_decider flow_decider_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .pc(pc), .ret_pc(ret_pc),
  .next_two_word(next_two_word), .br_take(br_take), .skip_hit(skip_hit),
  .is_ret(is_ret), .is_cond_br(is_cond_br), .res_valid(res_valid),
  .redirect(redirect), .skipped(skipped), .next_pc(next_pc), .cycles(cycles)
);

// File: tb/flow_decider_test.sv
module flow_decider_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [3:0]  op;
  logic [9:0]  pc;
  logic [7:0]  sreg;
  logic [2:0]  sel;
  logic [11:0] offset;
  logic        test_bit;
  logic [7:0]  reg_a;
  logic [7:0]  reg_b;
  logic        next_two_word;
  logic [9:0]  ret_pc;
  logic        res_valid;
  logic        redirect;
  logic        skipped;
  logic [9:0]  next_pc;
  logic [2:0]  cycles;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  flow_decider uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .pc(pc),
    .sreg(sreg), .sel(sel), .offset(offset), .test_bit(test_bit),
    .reg_a(reg_a), .reg_b(reg_b), .next_two_word(next_two_word),
    .ret_pc(ret_pc), .res_valid(res_valid), .redirect(redirect),
    .skipped(skipped), .next_pc(next_pc), .cycles(cycles)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [9:0]  pc;
    logic [7:0]  sreg;
    logic [2:0]  sel;
    logic [11:0] off;
    logic        tb;
    logic [7:0]  a;
    logic [7:0]  b;
    logic        len2;
    logic [9:0]  ret;
    logic [7:0]  req;
    logic        e_redir;
    logic        e_skip;
    logic [9:0]  e_pc;
    logic [2:0]  e_cyc;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    // R3 sequential
    '{4'd0,  10'h005, 8'h00, 3'd0, 12'h000, 1'b0, 8'h00, 8'h01, 1'b0, 10'h000, 8'd3,  1'b0, 1'b0, 10'h006, 3'd1},
    // R4 branch on zero flag set: taken / not taken
    '{4'd1,  10'h010, 8'h02, 3'd1, 12'h004, 1'b0, 8'h00, 8'h01, 1'b0, 10'h000, 8'd4,  1'b1, 1'b0, 10'h015, 3'd2},
    '{4'd1,  10'h010, 8'h00, 3'd1, 12'h004, 1'b0, 8'h00, 8'h01, 1'b0, 10'h000, 8'd7,  1'b0, 1'b0, 10'h011, 3'd1},
    // R4 branch on carry clear, backward offset (R6)
    '{4'd2,  10'h020, 8'h00, 3'd0, 12'hFFE, 1'b0, 8'h00, 8'h01, 1'b0, 10'h000, 8'd6,  1'b1, 1'b0, 10'h01F, 3'd2},
    '{4'd2,  10'h020, 8'h01, 3'd0, 12'hFFE, 1'b0, 8'h00, 8'h01, 1'b0, 10'h000, 8'd4,  1'b0, 1'b0, 10'h021, 3'd1},
    // R5 signed ge: N=1 V=1 -> taken
    '{4'd3,  10'h100, 8'h0C, 3'd0, 12'h010, 1'b0, 8'h00, 8'h01, 1'b0, 10'h000, 8'd5,  1'b1, 1'b0, 10'h111, 3'd2},
    // R5 signed lt: N=1 V=0 -> taken
    '{4'd4,  10'h100, 8'h04, 3'd0, 12'hFF0, 1'b0, 8'h00, 8'h01, 1'b0, 10'h000, 8'd5,  1'b1, 1'b0, 10'h0F1, 3'd2},
    // R5 signed lt with only sign bit set -> not taken
    '{4'd4,  10'h100, 8'h10, 3'd0, 12'hFF0, 1'b0, 8'h00, 8'h01, 1'b0, 10'h000, 8'd5,  1'b0, 1'b0, 10'h101, 3'd1},
    // R8 jump forward wrapping past top (R6)
    '{4'd5,  10'h3FF, 8'h00, 3'd0, 12'h001, 1'b0, 8'h00, 8'h01, 1'b0, 10'h000, 8'd8,  1'b1, 1'b0, 10'h001, 3'd2},
    // R6 jump backward wrapping below zero
    '{4'd5,  10'h002, 8'h00, 3'd0, 12'hFFC, 1'b0, 8'h00, 8'h01, 1'b0, 10'h000, 8'd6,  1'b1, 1'b0, 10'h3FF, 3'd2},
    // R9 relative call
    '{4'd6,  10'h050, 8'h00, 3'd0, 12'h020, 1'b0, 8'h00, 8'h01, 1'b0, 10'h000, 8'd9,  1'b1, 1'b0, 10'h071, 3'd3},
    // R10 return and interrupt return
    '{4'd7,  10'h050, 8'h00, 3'd0, 12'h020, 1'b0, 8'h00, 8'h01, 1'b0, 10'h123, 8'd10, 1'b1, 1'b0, 10'h123, 3'd4},
    '{4'd8,  10'h050, 8'h00, 3'd0, 12'h020, 1'b0, 8'h00, 8'h01, 1'b0, 10'h2AA, 8'd10, 1'b1, 1'b0, 10'h2AA, 3'd4},
    // R11 equality skip over a one-word instruction
    '{4'd9,  10'h040, 8'h00, 3'd0, 12'h000, 1'b0, 8'h5A, 8'h5A, 1'b0, 10'h000, 8'd11, 1'b0, 1'b1, 10'h042, 3'd2},
    // R12 equality skip not taken
    '{4'd9,  10'h040, 8'h00, 3'd0, 12'h000, 1'b0, 8'h5A, 8'h5B, 1'b0, 10'h000, 8'd12, 1'b0, 1'b0, 10'h041, 3'd1},
    // R12 clear-bit skip over a two-word instruction
    '{4'd10, 10'h040, 8'h00, 3'd0, 12'h000, 1'b0, 8'h00, 8'h01, 1'b1, 10'h000, 8'd12, 1'b0, 1'b1, 10'h043, 3'd3},
    // R11 set-bit skip not taken
    '{4'd11, 10'h040, 8'h00, 3'd0, 12'h000, 1'b0, 8'h00, 8'h01, 1'b1, 10'h000, 8'd11, 1'b0, 1'b0, 10'h041, 3'd1},
    // R11 set-bit skip over two words, wrapping
    '{4'd11, 10'h3FE, 8'h00, 3'd0, 12'h000, 1'b1, 8'h00, 8'h01, 1'b1, 10'h000, 8'd11, 1'b0, 1'b1, 10'h001, 3'd3},
    // R6 largest positive offset on interrupt-enable bit
    '{4'd1,  10'h000, 8'h80, 3'd7, 12'h7FF, 1'b0, 8'h00, 8'h01, 1'b0, 10'h000, 8'd6,  1'b1, 1'b0, 10'h000, 3'd2},
    // R3 undefined code acts sequential
    '{4'd15, 10'h007, 8'hFF, 3'd0, 12'h100, 1'b1, 8'h00, 8'h00, 1'b1, 10'h155, 8'd3,  1'b0, 1'b0, 10'h008, 3'd1}
  };

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check_outs(input string tag, input logic v, input logic r,
                            input logic s, input logic [9:0] p, input logic [2:0] c);
    checks++;
    if (res_valid !== v || redirect !== r || skipped !== s || next_pc !== p || cycles !== c) begin
      errors++;
      $display("FAIL %s: got valid=%b redir=%b skip=%b pc=%h cyc=%0d, expected valid=%b redir=%b skip=%b pc=%h cyc=%0d",
               tag, res_valid, redirect, skipped, next_pc, cycles, v, r, s, p, c);
    end
  endtask

  task automatic drive(input vec_t v);
    op = v.op; pc = v.pc; sreg = v.sreg; sel = v.sel; offset = v.off;
    test_bit = v.tb; reg_a = v.a; reg_b = v.b; next_two_word = v.len2; ret_pc = v.ret;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      summary();
    end
  end

  initial begin
    rst = 1'b1;
    op_valid = 1'b1;
    drive(VECS[1]);
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset despite a valid operation
    check_outs("R1 reset", 1'b0, 1'b0, 1'b0, 10'h000, 3'd0);
    rst = 1'b0;
    op_valid = 1'b0;
    @(negedge clk);
    // R2: idle cycle gives no result
    checks++;
    if (res_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 idle: got res_valid=%b, expected 0", res_valid);
    end

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i]);
      op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      check_outs($sformatf("R%0d vec%0d", VECS[i].req, i), 1'b1,
                 VECS[i].e_redir, VECS[i].e_skip, VECS[i].e_pc, VECS[i].e_cyc);
    end

    // R2: result lasts a single cycle after one operation
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 single pulse: got res_valid=%b, expected 0", res_valid);
    end

    // R7: back-to-back branch taken then not taken
    drive(VECS[1]);
    op_valid = 1'b1;
    @(negedge clk);
    check_outs("R7 back-to-back taken", 1'b1, 1'b1, 1'b0, 10'h015, 3'd2);
    drive(VECS[2]);
    @(negedge clk);
    op_valid = 1'b0;
    check_outs("R7 back-to-back not taken", 1'b1, 1'b0, 1'b0, 10'h011, 3'd1);

    // R1: reset after activity clears outputs again
    rst = 1'b1;
    @(negedge clk);
    check_outs("R1 reset after use", 1'b0, 1'b0, 1'b0, 10'h000, 3'd0);
    rst = 1'b0;

    done = 1'b1;
    summary();
  end

endmodule